// File: doc/BRIEF.md
# Reloadable Cycle-Count Interrupt Timer

This block is a down-counting interrupt timer for a cartridge-side CPU bus. It advances once per CPU clock. Software uses it to raise an interrupt a known number of CPU cycles after it starts the count, for example to split the screen at a chosen scanline.

Software writes the reload value one byte at a time into a holding latch. A separate strobe register then copies the whole latch into the live counter. One enable bit gates counting, and with it the interrupt. When the count steps down to zero, the counter parks there and pulls the active-low interrupt line. The line stays low until software writes the enable register. The timer fires again only after a fresh reload.

Top module: `cyc_timer`

## Requirements
- R1: After reset, `irq_n` is high, the enable bit is 0, and both the counter and the reload latch hold 0.
- R2: A write happens on a rising `clk` edge only when `cpu_rw` is 0 and `cpu_addr[15:12]` is 4'b1001. The register is then picked by `cpu_addr[2:0]`, and `cpu_addr[11:3]` are don't-care, so the registers mirror across that range. Any other address has no effect.
- R3: Select value 5 writes the upper byte of the reload latch and select 6 writes the lower byte. Select 4, whatever the data, copies the latch into the counter. Latch writes alone leave the counter untouched.
- R4: While enabled, the counter drops by one on every clock. The edge on which it steps from 1 to 0 drives `irq_n` low. If the counter is loaded with N while enabled, `irq_n` is low after exactly N further edges.
- R5: At zero the counter stays at zero. `irq_n` stays low until acknowledged. After an acknowledge, no new interrupt occurs until the next reload.
- R6: Any write to select 3 clears a pending interrupt, whatever byte is written.
- R7: Bit 7 of the byte written to select 3 is the enable bit. A 0 freezes the count where it is. A later 1 resumes from that frozen value, and the edge of the enabling write does not count.
- R8: A reload while the counter is running restarts it from the latch value. The edge of the reload write itself does not decrement.
- R9: Loading 0 never raises an interrupt. Loading 1 while enabled raises it one edge later.
- R10: Bus cycles with `cpu_rw` high change no timer state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; one count per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | CPU read/write, 0 means write |
| irq_n | output | 1 | Active-low interrupt, held until acknowledged |

## Verification
The assertions assume a single bus access per clock, with the address, data and R/W stable around the rising edge. They also treat the decoded write strobes as mutually exclusive, because only one select value can be present at a time.

The bench drives every bus cycle on the falling edge and returns to an idle read of address 0 between writes, so no stray strobe appears. Interrupt timing is checked by counting rising edges between the last write and the fall of `irq_n`.

// File: rtl/cyct_pkg.sv
package cyct_pkg;

   // register select values taken from the low address bits
   typedef enum logic [2:0] {
      SEL_ENABLE   = 3'd3,
      SEL_RELOAD   = 3'd4,
      SEL_LATCH_HI = 3'd5,
      SEL_LATCH_LO = 3'd6
   } cyct_sel_e;

   // one-cycle write strobes produced by the decoder
   typedef struct packed {
      logic enable;
      logic reload;
      logic latch_hi;
      logic latch_lo;
   } cyct_wr_s;

endpackage

// File: rtl/cyct_decode.sv
module cyct_decode
   import cyct_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int PAGE_W   = 4,
   parameter int SEL_W    = 3,
   parameter int PAGE_VAL = 9
) (
   input  logic [PAGE_W-1:0] page_bits,
   input  logic [SEL_W-1:0]  sel_bits,
   input  logic              cpu_rw,
   output cyct_wr_s          wr
);

   localparam logic [PAGE_W-1:0] PAGE_MATCH = PAGE_W'(PAGE_VAL);

   logic hit;

   if (ADDR_W < PAGE_W + SEL_W) begin : g_bad_addr
      $error("cyct_decode: address too narrow for page and select fields");
   end

   assign hit = (page_bits == PAGE_MATCH) && !cpu_rw;

   always_comb begin
      wr = '0;
      if (hit) begin
         unique case (sel_bits)
            SEL_W'(SEL_ENABLE):   wr.enable   = 1'b1;
            SEL_W'(SEL_RELOAD):   wr.reload   = 1'b1;
            SEL_W'(SEL_LATCH_HI): wr.latch_hi = 1'b1;
            SEL_W'(SEL_LATCH_LO): wr.latch_lo = 1'b1;
            default:              wr = '0;
         endcase
      end
   end

endmodule

// File: rtl/cyct_latch.sv
module cyct_latch #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [CNT_W/DATA_W-1:0]      byte_we,
   input  logic [DATA_W-1:0]            wdata,
   output logic [CNT_W-1:0]             value
);

   localparam int BYTES = CNT_W / DATA_W;

   if (BYTES * DATA_W != CNT_W) begin : g_bad_split
      $error("cyct_latch: counter width must be a whole number of bytes");
   end

   // one independently written register per byte lane
   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            value[b*DATA_W +: DATA_W] <= '0;
         else if (byte_we[b])
            value[b*DATA_W +: DATA_W] <= wdata;
      end
   end

endmodule

// File: rtl/cyct_counter.sv
module cyct_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_wr,
   input  logic             en_val,
   input  logic             reload,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             en_q,
   output logic             irq_q
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic terminal;
   logic step;

   // counting uses the enable value held before this edge
   assign step     = en_q && !reload && (cnt != '0);
   assign terminal = step && (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (reload)
         cnt <= load_val;
      else if (step)
         cnt <= cnt - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (en_wr)
         en_q <= en_val;
   end

   // a new terminal event beats an acknowledge on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else
         irq_q <= terminal | (irq_q & ~en_wr);
   end

endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
   import cyct_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int CNT_W    = 16,
   parameter int PAGE_W   = 4,
   parameter int PAGE_VAL = 9,
   parameter int SEL_W    = 3,
   parameter int EN_BIT   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              cpu_rw,
   output logic              irq_n
);

   localparam int BYTES = CNT_W / DATA_W;

   if (BYTES != 2) begin : g_bad_bytes
      $error("cyc_timer: exactly two byte lanes are addressable");
   end
   if (EN_BIT >= DATA_W) begin : g_bad_en
      $error("cyc_timer: enable bit outside data bus");
   end

   cyct_wr_s         wr_s;
   logic [CNT_W-1:0] latch_q;
   logic [CNT_W-1:0] cnt_q;
   logic             en_q;
   logic             irq_q;
   logic             unused_addr_bits;

   assign unused_addr_bits = ^cpu_addr[ADDR_W-PAGE_W-1:SEL_W];

   cyct_decode #(
      .ADDR_W  (ADDR_W),
      .PAGE_W  (PAGE_W),
      .SEL_W   (SEL_W),
      .PAGE_VAL(PAGE_VAL)
   ) u_decode (
      .page_bits(cpu_addr[ADDR_W-1 -: PAGE_W]),
      .sel_bits (cpu_addr[SEL_W-1:0]),
      .cpu_rw   (cpu_rw),
      .wr       (wr_s)
   );

   cyct_latch #(
      .DATA_W(DATA_W),
      .CNT_W (CNT_W)
   ) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .byte_we({wr_s.latch_hi, wr_s.latch_lo}),
      .wdata  (cpu_data),
      .value  (latch_q)
   );

   cyct_counter #(
      .CNT_W(CNT_W)
   ) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_wr   (wr_s.enable),
      .en_val  (cpu_data[EN_BIT]),
      .reload  (wr_s.reload),
      .load_val(latch_q),
      .cnt     (cnt_q),
      .en_q    (en_q),
      .irq_q   (irq_q)
   );

   assign irq_n = ~irq_q;

endmodule

// File: rtl/cyct_checker.sv
module cyct_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_rw,
   input logic             irq_n,
   input logic             wr_enable,
   input logic             wr_reload,
   input logic             wr_hi,
   input logic             wr_lo,
   input logic             en_q,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] latch
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_enable, wr_reload, wr_hi, wr_lo}));

   p_read_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rw |-> !(wr_enable || wr_reload || wr_hi || wr_lo));

   p_reload_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reload |=> cnt == $past(latch));

   p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !wr_reload && cnt != '0) |=> cnt == $past(cnt) - ONE);

   p_fire_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> cnt == '0);

   p_park_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !wr_reload) |=> cnt == '0);

   p_irq_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !wr_enable) |=> !irq_n);

   p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_enable && !(en_q && !wr_reload && cnt == ONE)) |=> irq_n);

   p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !wr_reload) |=> $stable(cnt));

endmodule

bind cyc_timer cyct_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_rw   (cpu_rw),
   .irq_n    (irq_n),
   .wr_enable(wr_s.enable),
   .wr_reload(wr_s.reload),
   .wr_hi    (wr_s.latch_hi),
   .wr_lo    (wr_s.latch_lo),
   .en_q     (en_q),
   .cnt      (cnt_q),
   .latch    (latch_q)
);

// File: tb/cyc_timer_bench.sv
module cyc_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_data = 8'h00;
   logic        cpu_rw = 1'b1;
   logic        irq_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   cyc_timer u_cyc_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .cpu_addr(cpu_addr),
      .cpu_data(cpu_data),
      .cpu_rw  (cpu_rw),
      .irq_n   (irq_n)
   );

   task automatic check(string req, int actual, int expected);
      checks++;
      if (actual != expected) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic bus_write(logic [15:0] a, logic [7:0] d);
      cpu_addr = a; cpu_data = d; cpu_rw = 1'b0;
      @(posedge clk);
      @(negedge clk);
      cpu_addr = 16'h0000; cpu_data = 8'h00; cpu_rw = 1'b1;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic edges_to_irq(int limit, output int k);
      k = 0;
      while (irq_n && k < limit) begin
         @(posedge clk);
         @(negedge clk);
         k++;
      end
   endtask

   task automatic load(int v);
      bus_write(16'h9005, v[15:8]);
      bus_write(16'h9006, v[7:0]);
   endtask

   task automatic t_reset();
      check("R1 irq_n after reset", irq_n, 1);
      bus_write(16'h9003, 8'h80);
      idle(40);
      check("R1 zero counter with no load stays quiet", irq_n, 1);
      bus_write(16'h9004, 8'h00);
      idle(20);
      check("R1 reset latch of zero gives no irq", irq_n, 1);
   endtask

   task automatic t_basic();
      int k;
      load(10);
      check("R3 latch writes leave counter idle", irq_n, 1);
      bus_write(16'h9004, 8'h5A);
      edges_to_irq(500, k);
      check("R4 cycles to irq for 10", k, 10);
      load(16'h0100);
      bus_write(16'h9003, 8'h80);
      bus_write(16'h9004, 8'h00);
      edges_to_irq(1000, k);
      check("R3 high byte load 256", k, 256);
   endtask

   task automatic t_hold();
      int k;
      load(6);
      bus_write(16'h9003, 8'h80);
      bus_write(16'h9004, 8'h00);
      edges_to_irq(100, k);
      check("R4 cycles for 6", k, 6);
      idle(50);
      check("R5 irq held low", irq_n, 0);
      bus_write(16'h9003, 8'h80);
      check("R6 ack with 0x80", irq_n, 1);
      idle(100);
      check("R5 no refire after halt", irq_n, 1);
      load(3);
      bus_write(16'h9004, 8'h00);
      edges_to_irq(100, k);
      check("R5 refire after reload", k, 3);
      bus_write(16'h9003, 8'h55);
      check("R6 ack with 0x55", irq_n, 1);
   endtask

   task automatic t_pause();
      int k;
      bus_write(16'h9003, 8'h00);
      load(5);
      bus_write(16'h9004, 8'h00);
      idle(30);
      check("R7 disabled counter quiet", irq_n, 1);
      bus_write(16'h9003, 8'h80);
      edges_to_irq(100, k);
      check("R7 start after enable", k, 5);
      load(20);
      bus_write(16'h9004, 8'h00);
      idle(5);
      bus_write(16'h9003, 8'h7F);
      idle(10);
      check("R7 paused no irq", irq_n, 1);
      bus_write(16'h9003, 8'h80);
      edges_to_irq(100, k);
      check("R7 resume remainder", k, 14);
   endtask

   task automatic t_restart();
      int k;
      bus_write(16'h9003, 8'h80);
      load(30);
      bus_write(16'h9004, 8'h00);
      idle(10);
      bus_write(16'h9004, 8'h00);
      edges_to_irq(100, k);
      check("R8 restart from latch", k, 30);
      bus_write(16'h9003, 8'h80);
      load(0);
      bus_write(16'h9004, 8'h00);
      idle(40);
      check("R9 zero load no irq", irq_n, 1);
      load(1);
      bus_write(16'h9004, 8'h00);
      edges_to_irq(10, k);
      check("R9 load one", k, 1);
      bus_write(16'h9003, 8'h80);
   endtask

   task automatic t_decode();
      int k;
      load(7);
      bus_write(16'hA006, 8'h40);
      bus_write(16'h8005, 8'h12);
      cpu_addr = 16'h9006; cpu_data = 8'h33; cpu_rw = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cpu_addr = 16'h0000; cpu_data = 8'h00;
      bus_write(16'hB004, 8'h00);
      idle(20);
      check("R2 foreign reload ignored", irq_n, 1);
      bus_write(16'h9004, 8'h00);
      edges_to_irq(100, k);
      check("R10 R2 latch unchanged by read and foreign page", k, 7);
      bus_write(16'h9FFB, 8'h80);
      check("R2 mirrored ack", irq_n, 1);
      bus_write(16'h9F0E, 8'h09);
      bus_write(16'h9A3C, 8'h00);
      edges_to_irq(100, k);
      check("R2 mirrored latch and reload", k, 9);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_hold();
      t_pause();
      t_restart();
      t_decode();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule